// File: doc/BRIEF.md
# Single-Frame Receive Buffer with Byte-Serial Host Readout

This block holds one incoming Ethernet frame and lets a host drain it one byte per access. The network side presents the frame as a stream of byte beats with a marker on the final beat. The block offers a ready signal and takes every frame, with no filtering, whenever the buffer is not full. When the final beat is taken, the frame becomes the stored frame. The block then pulses a receive-done event for the interrupt controller.

The host reads two locations. One returns the number of bytes that remain. The other returns the next byte and advances the read position. Host writes are allowed on the bus, but they change nothing. The frame's length is the number of beats up to and including the final one. Storage is capped at 1514 bytes, and any bytes beyond the cap are dropped.

Top module: `rx_frame_buf`

## Requirements
- R1: After reset the remaining count reads 0, `net_ready_o` is 1, `rx_done_o` is 0, a data read returns 0 and the whole storage is cleared.
- R2: `net_ready_o` is 1 exactly while the remaining count is below 1514. A beat offered while it is 0 is dropped: no storage write, no count change, no done pulse.
- R3: A final beat taken at a clock edge makes the remaining count equal to the frame length and the read position 0 at that edge. `rx_done_o` is 1 for the cycle that follows.
- R4: A host read with `host_sel_i`=1 and a nonzero count returns, one cycle later on `host_rdata_o[7:0]` with the upper bits zero, the byte at the read position. The first byte of the frame is at position 0. The read then increments the position and decrements the count.
- R5: A data read while the count is 0 returns 0 and leaves the count and the position unchanged.
- R6: A read with `host_sel_i`=0 returns the remaining count, zero-extended, one cycle later and changes nothing. An access with `host_we_i`=1 at either location changes no state.
- R7: In a frame longer than 1514 beats, only the first 1514 bytes are stored and the count becomes 1514.
- R8: A new frame accepted before the old one is drained replaces it. The count and position reload, and reads return the new bytes from position 0.
- R9: When a data read falls in the same cycle as an accepted final beat, the read returns the byte stored at the old position before that edge. The count and position take the new frame's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| net_valid_i | input | 1 | Network beat valid |
| net_data_i | input | 8 | Network beat byte |
| net_last_i | input | 1 | Beat is the final byte of the frame |
| net_ready_o | output | 1 | Buffer can take a frame (not full) |
| rx_done_o | output | 1 | One-cycle pulse after a frame is accepted |
| host_req_i | input | 1 | Host access strobe |
| host_we_i | input | 1 | Access is a write (ignored) |
| host_sel_i | input | 1 | 0: remaining count, 1: data byte |
| host_rdata_o | output | DATA_W | Read result, valid the cycle after the strobe |

## Verification
Frame acceptance and a host data read can land on the same clock edge. Both of them update the count and the read position. The bench provokes this in two steps. It first drains part of a long frame, so that the old read position lies beyond the bytes the short new frame writes. It then issues a data read on the cycle of that frame's final beat. The bench expects the returned byte to come from the old frame. It expects the count to equal the new frame's length and the next read to return the new frame's first byte. It does not expect a count reduced by that read.

// File: rtl/rxb_pkg.sv
`timescale 1ns/1ps
package rxb_pkg;
  parameter int RXB_DEPTH = 1514;

  typedef enum logic {
    SEL_COUNT = 1'b0,
    SEL_DATA  = 1'b1
  } rxb_sel_e;
endpackage

// File: rtl/rxb_store.sv
`timescale 1ns/1ps
module rxb_store #(
  parameter int DEPTH = 1514,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_addr_i,
  input  logic [7:0]       wr_byte_i,
  input  logic [PTR_W-1:0] rd_addr_i,
  output logic [7:0]       rd_byte_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_byte_i;
    end
  end

  assign rd_byte_o = (32'(rd_addr_i) < DEPTH) ? mem_q[rd_addr_i] : 8'h00;
endmodule

// File: rtl/rxb_fill.sv
`timescale 1ns/1ps
module rxb_fill #(
  parameter int DEPTH = 1514,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             last_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic             accept_o,
  output logic [CNT_W-1:0] len_o,
  output logic             done_o
);
  logic [CNT_W-1:0] wr_ptr_q;
  logic             room;

  assign room      = 32'(wr_ptr_q) < DEPTH;
  assign wr_en_o   = beat_i && room;
  assign wr_addr_o = PTR_W'(wr_ptr_q);
  assign accept_o  = beat_i && last_i;
  assign len_o     = room ? wr_ptr_q + 1'b1 : wr_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= accept_o;
      if (beat_i) begin
        if (last_i)    wr_ptr_q <= '0;
        else if (room) wr_ptr_q <= wr_ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxb_drain.sv
`timescale 1ns/1ps
module rxb_drain
  import rxb_pkg::*;
#(
  parameter int DEPTH  = 1514,
  parameter int DATA_W = 16,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              req_i,
  input  logic              we_i,
  input  rxb_sel_e          sel_i,
  input  logic [7:0]        byte_i,
  output logic [PTR_W-1:0]  pos_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic rd_req, data_rd, have_byte;

  assign rd_req    = req_i && !we_i;
  assign data_rd   = rd_req && (sel_i == SEL_DATA);
  assign have_byte = cnt_o != '0;
  assign full_o    = 32'(cnt_o) >= DEPTH;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      pos_o <= '0;
    end else if (accept_i) begin
      // new frame wins over a coincident read
      cnt_o <= len_i;
      pos_o <= '0;
    end else if (data_rd && have_byte) begin
      cnt_o <= cnt_o - 1'b1;
      pos_o <= pos_o + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_req) begin
      if (sel_i == SEL_COUNT) rdata_o <= DATA_W'(cnt_o);
      else                    rdata_o <= have_byte ? DATA_W'(byte_i) : '0;
    end
  end
endmodule

// File: rtl/rx_frame_buf.sv
`timescale 1ns/1ps
module rx_frame_buf
  import rxb_pkg::*;
#(
  parameter int DEPTH  = rxb_pkg::RXB_DEPTH,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              net_valid_i,
  input  logic [7:0]        net_data_i,
  input  logic              net_last_i,
  output logic              net_ready_o,
  output logic              rx_done_o,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic              host_sel_i,
  output logic [DATA_W-1:0] host_rdata_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             beat, wr_en, accept, full;
  logic [PTR_W-1:0] wr_addr, pos_w;
  logic [CNT_W-1:0] len_w, cnt_w;
  logic [7:0]       rd_byte;
  rxb_sel_e         sel;

  assign sel         = rxb_sel_e'(host_sel_i);
  assign net_ready_o = !full;
  assign beat        = net_valid_i && net_ready_o;

  rxb_fill #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_fill (
    .clk_i, .rst_ni,
    .beat_i    (beat),
    .last_i    (net_last_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .accept_o  (accept),
    .len_o     (len_w),
    .done_o    (rx_done_o)
  );

  rxb_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_byte_i (net_data_i),
    .rd_addr_i (pos_w),
    .rd_byte_o (rd_byte)
  );

  rxb_drain #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_drain (
    .clk_i, .rst_ni,
    .accept_i (accept),
    .len_i    (len_w),
    .req_i    (host_req_i),
    .we_i     (host_we_i),
    .sel_i    (sel),
    .byte_i   (rd_byte),
    .pos_o    (pos_w),
    .cnt_o    (cnt_w),
    .full_o   (full),
    .rdata_o  (host_rdata_o)
  );
endmodule

// File: rtl/rx_frame_buf_chk.sv
`timescale 1ns/1ps
module rx_frame_buf_chk #(
  parameter int DEPTH  = 1514,
  parameter int DATA_W = 16,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              net_valid_i,
  input logic              net_last_i,
  input logic              net_ready_o,
  input logic              rx_done_o,
  input logic              host_req_i,
  input logic              host_we_i,
  input logic              host_sel_i,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [PTR_W-1:0]  pos_i
);
  logic acc, drd;
  assign acc = net_valid_i && net_ready_o && net_last_i;
  assign drd = host_req_i && !host_we_i && host_sel_i;

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rx_done_o && cnt_i != '0 && pos_i == '0);

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drd && cnt_i != '0 && !acc) |=>
      cnt_i == $past(cnt_i) - 1'b1 && pos_i == $past(pos_i) + 1'b1);

  p_empty_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drd && cnt_i == '0 && !acc) |=>
      host_rdata_o == '0 && cnt_i == '0 && pos_i == $past(pos_i));

  p_write_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && host_we_i && !acc) |=>
      cnt_i == $past(cnt_i) && pos_i == $past(pos_i));

  p_full_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!net_ready_o && !drd) |=> !net_ready_o && !rx_done_o);

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_i) <= DEPTH);
endmodule

bind rx_frame_buf rx_frame_buf_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .net_valid_i, .net_last_i, .net_ready_o, .rx_done_o,
  .host_req_i, .host_we_i, .host_sel_i, .host_rdata_o,
  .cnt_i (cnt_w),
  .pos_i (pos_w)
);

// File: tb/rx_frame_buf_test.sv
`timescale 1ns/1ps
module rx_frame_buf_test;
  localparam int DEPTH = 1514;
  localparam int DW    = 16;
  localparam int NT    = 5;
  localparam int T_LEN  [NT] = '{1, 5, 64, 1514, 1600};
  localparam int T_SEED [NT] = '{8'hA5, 8'h10, 8'h3C, 8'h00, 8'h77};

  logic clk = 0, rst_ni = 0;
  logic net_valid = 0, net_last = 0, net_ready, rx_done;
  logic [7:0] net_data = 0;
  logic host_req = 0, host_we = 0, host_sel = 0;
  logic [DW-1:0] host_rdata;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rx_frame_buf #(.DEPTH(DEPTH), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni, .net_valid_i(net_valid), .net_data_i(net_data),
    .net_last_i(net_last), .net_ready_o(net_ready), .rx_done_o(rx_done),
    .host_req_i(host_req), .host_we_i(host_we), .host_sel_i(host_sel),
    .host_rdata_o(host_rdata)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_frame(int len, int seed, bit rd_on_last);
    for (int i = 0; i < len; i++) begin
      net_valid = 1; net_data = 8'((seed + i) & 255); net_last = (i == len - 1);
      if (net_last && rd_on_last) begin host_req = 1; host_we = 0; host_sel = 1; end
      step();
    end
    net_valid = 0; net_last = 0; host_req = 0;
  endtask

  task automatic host_rd(bit sel, output int val);
    host_req = 1; host_we = 0; host_sel = sel;
    step();
    host_req = 0;
    val = int'(host_rdata);
  endtask

  task automatic host_wr(bit sel);
    host_req = 1; host_we = 1; host_sel = sel;
    step();
    host_req = 0; host_we = 0;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, exp_n;
    #5 rst_ni = 1;
    step();
    // R1 reset state
    check("R1 ready", int'(net_ready), 1);
    check("R1 done", int'(rx_done), 0);
    host_rd(0, v); check("R1 count", v, 0);
    host_rd(1, v); check("R1 data", v, 0);

    // table walk: frame lengths and seeds
    for (int t = 0; t < NT; t++) begin
      exp_n = (T_LEN[t] < DEPTH) ? T_LEN[t] : DEPTH;
      send_frame(T_LEN[t], T_SEED[t], 0);
      check("R3 done pulse", int'(rx_done), 1);
      step();
      check("R3 done width", int'(rx_done), 0);
      host_rd(0, v); check("R3/R7 count", v, exp_n);
      check("R2 ready level", int'(net_ready), (exp_n < DEPTH) ? 1 : 0);
      if (exp_n == DEPTH) begin
        net_valid = 1; net_data = 8'hEE; net_last = 1;
        step();
        net_valid = 0; net_last = 0;
        step();
        check("R2 dropped beat done", int'(rx_done), 0);
        host_rd(0, v); check("R2 dropped beat count", v, DEPTH);
      end
      host_wr(0); host_wr(1);
      host_rd(0, v); check("R6 write ignored", v, exp_n);
      for (int i = 0; i < exp_n; i++) begin
        host_rd(1, v); check("R4 byte", v, (T_SEED[t] + i) & 255);
      end
      host_rd(1, v); check("R5 empty data", v, 0);
      host_rd(0, v); check("R5 count stays", v, 0);
      check("R2 ready after drain", int'(net_ready), 1);
    end

    // R8 replace undrained frame
    send_frame(6, 8'h40, 0);
    host_rd(1, v); host_rd(1, v); check("R8 old byte", v, 8'h41);
    send_frame(3, 8'h90, 0);
    host_rd(0, v); check("R8 count reload", v, 3);
    host_rd(1, v); check("R8 new first", v, 8'h90);
    for (int i = 0; i < 2; i++) host_rd(1, v);
    check("R8 new last", v, 8'h92);

    // R9 read coinciding with final beat
    send_frame(8, 8'h20, 0);
    for (int i = 0; i < 3; i++) host_rd(1, v);
    send_frame(2, 8'hC0, 1);
    check("R9 old byte", int'(host_rdata), 8'h23);
    host_rd(0, v); check("R9 count", v, 2);
    host_rd(1, v); check("R9 new first", v, 8'hC0);
    host_rd(1, v); check("R9 new second", v, 8'hC1);
    host_rd(1, v); check("R9 empty", v, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule